// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The resolver merges two sources of interrupt requests into one priority decision. The first source is a software request register, in which fifteen bit positions each stand for one software priority. The second is a vector of external request lines, in which the bit position of each line is its priority. On every enabled evaluation cycle the block finds the single winning level, builds a mask of every request that is pending, and compares the winning level with the processor's current priority level.

When the winning level is strictly higher than the current level, the block pulses a trap request for one cycle. In the same cycle it loads the pending mask into a summary register and the winning level into an interrupt identifier register. Both registers hold their values until the next trap. A nonzero asynchronous-trap request is not supported. It raises an error pulse in place of any trap. The logic that vectors to a handler and the logic that returns from the trap sit outside this block.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset, `trap_o`, `ast_err_o`, `isr_o` and `intid_o` are all zero.
- R2: A software request at bit position p of `sw_req`, with p from 4 to 18, stands for level p-3, giving levels 1 to 15. When no external request is pending, the highest pending software bit sets the winning level.
- R3: An external request at bit position p of `ext_req`, with p from 16 to 31, stands for level p. Any pending external request wins over every software request, and the highest pending external bit sets the winning level.
- R4: The summary mask is the OR of `sw_req` bits 4 to 18 and `ext_req` bits 16 to 31, each at its own bit position. `sw_req` bits 0 to 3 and 19 to 31, and `ext_req` bits 0 to 15, are ignored: they add nothing to the mask and nothing to the level.
- R5: A trap is raised only when the winning level is nonzero and strictly greater than `cur_ipl`. A level equal to `cur_ipl` raises no trap.
- R6: When a trap is raised, `isr_o` takes the summary mask and `intid_o` takes the winning level. In every other cycle both registers hold their values.
- R7: The results of an evaluation appear one clock edge after the edge at which `eval_en` is sampled high. `trap_o` is high for exactly one cycle for each evaluation that traps. When `eval_en` is low, no trap and no error is produced and the status registers are left unchanged.
- R8: When `ast_req` is nonzero in an enabled evaluation, `ast_err_o` pulses high one edge later, no trap is raised, and `isr_o` and `intid_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Evaluate the requests in this cycle |
| sw_req | input | 32 | Software request register; bits 4 to 18 are used |
| ext_req | input | 32 | External request lines; bits 16 to 31 are used |
| cur_ipl | input | 5 | Current processor priority level |
| ast_req | input | 4 | Asynchronous-trap request register; must be zero |
| trap_o | output | 1 | One-cycle trap request |
| isr_o | output | 32 | Interrupt summary register |
| intid_o | output | 5 | Interrupt identifier register (winning level) |
| ast_err_o | output | 1 | One-cycle unsupported-request error |

## Verification
Every result of the block (the trap pulse, the error pulse, the summary register and the identifier register) is due at the first rising edge after the one that samples `eval_en` high. The bench drives its inputs on a falling edge and drops `eval_en` on the next falling edge. It then reads all four outputs half a cycle after the capturing edge. One cycle later it samples again to confirm that the pulses have fallen and that the status registers have held their values.

// File: rtl/irqlv_pkg.sv
package irqlv_pkg;
  parameter int SUM_W  = 32;
  parameter int SW_LO  = 4;
  parameter int SW_N   = 15;
  parameter int EXT_LO = 16;
  parameter int EXT_N  = 16;
  parameter int LVL_W  = 5;
  parameter int AST_W  = 4;

  localparam int SW_IW  = (SW_N  > 1) ? $clog2(SW_N)  : 1;
  localparam int EXT_IW = (EXT_N > 1) ? $clog2(EXT_N) : 1;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [SUM_W-1:0] summary_t;

  function automatic summary_t field_mask(int lo, int n);
    summary_t m;
    m = '0;
    for (int i = 0; i < SUM_W; i++) begin
      if (i >= lo && i < lo + n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqlv_scan.sv
module irqlv_scan #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] top_idx
);
  always_comb begin
    hit     = 1'b0;
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        hit     = 1'b1;
        top_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqlv_merge.sv
module irqlv_merge
  import irqlv_pkg::*;
(
  input  logic              sw_hit,
  input  logic [SW_IW-1:0]  sw_idx,
  input  logic              ext_hit,
  input  logic [EXT_IW-1:0] ext_idx,
  output level_t            level
);
  always_comb begin
    if (ext_hit)
      level = LVL_W'(ext_idx) + LVL_W'(EXT_LO);
    else if (sw_hit)
      level = LVL_W'(sw_idx) + LVL_W'(1);
    else
      level = '0;
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irqlv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic [SUM_W-1:0] sw_req,
  input  logic [SUM_W-1:0] ext_req,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic [AST_W-1:0] ast_req,
  output logic             trap_o,
  output logic [SUM_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic             ast_err_o
);
  localparam int SW_HI  = SW_LO + SW_N - 1;
  localparam int EXT_HI = EXT_LO + EXT_N - 1;
  localparam summary_t SW_MASK  = field_mask(SW_LO, SW_N);
  localparam summary_t EXT_MASK = field_mask(EXT_LO, EXT_N);

  logic              sw_hit, ext_hit;
  logic [SW_IW-1:0]  sw_idx;
  logic [EXT_IW-1:0] ext_idx;
  level_t            level;
  summary_t          summary;
  logic              ast_bad, fire;

  // Synchronised reset release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  irqlv_scan #(.N(SW_N), .IW(SW_IW)) u_sw_scan (
    .req(sw_req[SW_HI:SW_LO]), .hit(sw_hit), .top_idx(sw_idx)
  );

  irqlv_scan #(.N(EXT_N), .IW(EXT_IW)) u_ext_scan (
    .req(ext_req[EXT_HI:EXT_LO]), .hit(ext_hit), .top_idx(ext_idx)
  );

  irqlv_merge u_merge (
    .sw_hit(sw_hit), .sw_idx(sw_idx),
    .ext_hit(ext_hit), .ext_idx(ext_idx),
    .level(level)
  );

  // Next-state logic
  logic     trap_d, err_d;
  summary_t isr_d;
  level_t   intid_d;

  always_comb begin
    summary = (sw_req & SW_MASK) | (ext_req & EXT_MASK);
    ast_bad = |ast_req;
    fire    = eval_en && !ast_bad && (level != '0) && (level > cur_ipl);
    trap_d  = fire;
    err_d   = eval_en && ast_bad;
    isr_d   = fire ? summary : isr_o;
    intid_d = fire ? level : intid_o;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_o    <= 1'b0;
      ast_err_o <= 1'b0;
      isr_o     <= '0;
      intid_o   <= '0;
    end else if (rst_s2) begin
      trap_o    <= trap_d;
      ast_err_o <= err_d;
      isr_o     <= isr_d;
      intid_o   <= intid_d;
    end
  end
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
  import irqlv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             eval_en,
  input logic [LVL_W-1:0] cur_ipl,
  input logic [AST_W-1:0] ast_req,
  input logic             trap_o,
  input logic [SUM_W-1:0] isr_o,
  input logic [LVL_W-1:0] intid_o,
  input logic             ast_err_o
);
  // R5: a trap's level is above the priority level seen at evaluation
  p_trap_above_ipl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && (ast_req == '0) && (cur_ipl == '1) |=> !trap_o);

  p_trap_level_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (intid_o != '0) && (isr_o != '0));

  // R6: status registers hold outside trap cycles
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(isr_o) && $stable(intid_o));

  // R7: no evaluation, no pulse
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> !trap_o && !ast_err_o);

  // R8: an unsupported request never traps
  p_ast_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && (ast_req != '0) |=> ast_err_o && !trap_o);

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ast_err_o && trap_o));
endmodule

bind irq_level_resolver irq_level_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .cur_ipl(cur_ipl),
  .ast_req(ast_req), .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o),
  .ast_err_o(ast_err_o)
);

// File: tb/sim_irq_level_resolver.sv
`timescale 1ns/1ps
module sim_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_en;
  logic [31:0] sw_req, ext_req;
  logic [4:0]  cur_ipl;
  logic [3:0]  ast_req;
  logic        trap_o, ast_err_o;
  logic [31:0] isr_o;
  logic [4:0]  intid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_isr;
  logic [4:0]  exp_id;

  always #5 clk = ~clk;

  irq_level_resolver u0 (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .sw_req(sw_req),
    .ext_req(ext_req), .cur_ipl(cur_ipl), .ast_req(ast_req),
    .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o), .ast_err_o(ast_err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the level scan and pending mask
  function automatic logic [4:0] ref_level(logic [31:0] s, logic [31:0] e);
    logic [4:0] l;
    l = 0;
    for (int i = 4; i <= 18; i++) if (s[i]) l = 5'(i - 3);
    for (int i = 16; i <= 31; i++) if (e[i]) l = 5'(i);
    return l;
  endfunction

  function automatic logic [31:0] ref_sum(logic [31:0] s, logic [31:0] e);
    logic [31:0] m;
    m = 0;
    for (int i = 4; i <= 18; i++) if (s[i]) m[i] = 1'b1;
    for (int i = 16; i <= 31; i++) if (e[i]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic run_eval(string req, logic [31:0] s, logic [31:0] e,
                          logic [4:0] ipl, logic [3:0] a);
    logic [4:0] lv;
    logic       tr, er;
    lv = ref_level(s, e);
    er = (a != 0);
    tr = !er && lv != 0 && lv > ipl;
    if (tr) begin
      exp_isr = ref_sum(s, e);
      exp_id  = lv;
    end
    @(negedge clk);
    sw_req = s; ext_req = e; cur_ipl = ipl; ast_req = a; eval_en = 1'b1;
    @(negedge clk);
    eval_en = 1'b0;
    check({req, " trap"}, 32'(trap_o), 32'(tr));
    check({req, " err"}, 32'(ast_err_o), 32'(er));
    check({req, " isr"}, isr_o, exp_isr);
    check({req, " intid"}, 32'(intid_o), 32'(exp_id));
    @(negedge clk);
    check({req, " R7 trap pulse ends"}, 32'(trap_o), 32'd0);
    check({req, " R8 err pulse ends"}, 32'(ast_err_o), 32'd0);
    check({req, " R6 isr held"}, isr_o, exp_isr);
  endtask

  task automatic t_reset();
    check("R1 trap", 32'(trap_o), 0);
    check("R1 err", 32'(ast_err_o), 0);
    check("R1 isr", isr_o, 0);
    check("R1 intid", 32'(intid_o), 0);
  endtask

  task automatic t_sw_only();
    run_eval("R2 sw 5,9", 32'h0000_0220, 0, 5'd0, 0);
    run_eval("R2 sw lowest bit", 32'h0000_0010, 0, 5'd0, 0);
    run_eval("R2 sw top bit", 32'h0004_0000, 0, 5'd14, 0);
  endtask

  task automatic t_ext_only();
    run_eval("R3 ext 20", 0, 32'h0010_0000, 5'd3, 0);
    run_eval("R3 ext 17,25", 0, 32'h0202_0000, 5'd0, 0);
  endtask

  task automatic t_mixed();
    run_eval("R3 mixed ext overrides", 32'h0004_0010, 32'h0002_0000, 5'd16, 0);
  endtask

  task automatic t_threshold();
    run_eval("R5 equal level", 0, 32'h0010_0000, 5'd20, 0);
    run_eval("R5 one above", 0, 32'h0010_0000, 5'd19, 0);
    run_eval("R5 level 31 at ipl 31", 0, 32'h8000_0000, 5'd31, 0);
    run_eval("R5 sw below ipl", 32'h0000_0100, 0, 5'd10, 0);
  endtask

  task automatic t_ignored();
    run_eval("R4 ignored bits", 32'hFFF8_000F, 32'h0000_FFFF, 5'd0, 0);
    run_eval("R5 all zero", 0, 0, 5'd0, 0);
  endtask

  task automatic t_ast();
    run_eval("R8 ast pending", 32'h0000_0400, 32'h4000_0000, 5'd0, 4'b0010);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    sw_req = 32'h0000_0800; ext_req = 32'h8000_0000; cur_ipl = 0;
    ast_req = 4'hF; eval_en = 1'b0;
    @(negedge clk);
    check("R7 disabled trap", 32'(trap_o), 0);
    check("R7 disabled err", 32'(ast_err_o), 0);
    @(negedge clk);
    check("R7 disabled isr held", isr_o, exp_isr);
    check("R7 disabled intid held", 32'(intid_o), 32'(exp_id));
  endtask

  initial begin
    rst_n = 1'b0; eval_en = 0; sw_req = 0; ext_req = 0; cur_ipl = 0; ast_req = 0;
    exp_isr = 0; exp_id = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_sw_only();
    t_ext_only();
    t_mixed();
    t_threshold();
    t_ignored();
    t_ast();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule